// File: doc/BRIEF.md
# Compensator Gain Autotuning Sequencer

This block adjusts the overall gain of a switching converter's feedback compensator while the converter keeps running. It sees only time-domain statistics of the compensated error signal, supplied by a separate monitor once per switching period. These are the peak-to-peak value of the error in that period and two flags that compare the change between consecutive peak-to-peak values against an upper and a lower threshold. A change above the upper threshold means the error no longer repeats at the switching frequency, so the loop is treated as unstable. A change below the lower threshold means the loop has settled.

A tuning cycle runs in four phases. The sequencer first checks for a steady operating point. It then makes a small down-and-back excursion to learn which direction of gain change enlarges the peak-to-peak value. Next it pushes the gain that way until the loop just turns unstable, and then backs off until the loop is stable again. That gain is latched and held for a while, after which a new cycle starts from the latched value. The gain is unsigned fixed point with five fraction bits, so one LSB is a step of 1/32.

Top module: `gain_autotune`

## Requirements
- R1: While reset is asserted and after reset, `gain` equals `cfg_gain_init` and `busy` is 1.
- R2: `gain` changes only in the clock cycle after a `period_stb` pulse. After any gain step, the next `cfg_settle` strobes are ignored: no step, no state change, flags and peak-to-peak value unused.
- R3: A tuning cycle begins once `cfg_steady` consecutive evaluated strobes have arrived with `unstable` low (0 counts as 1). The first step then lowers the gain by one LSB and records the peak-to-peak value as the reference.
- R4: Direction search takes `cfg_span` (S, 0 counts as 1) down steps and then S up steps, ending at the starting gain. Each evaluated strobe compares `pp_val` against the previous one. The direction is "up" if the last comparison of the up phase found a strictly larger value, otherwise "down". The strobe that ends the search also takes the first step in that direction.
- R5: In the climb phase, each evaluated strobe with `unstable` low steps the gain one LSB in the found direction. A strobe with `unstable` high instead steps one LSB in the opposite direction and enters back-off.
- R6: In back-off, each evaluated strobe with `stable` low steps one LSB opposite to the found direction. A strobe with `stable` high latches the gain unchanged and drops `busy` to 0.
- R7: While latched, the gain is held. A new cycle (`busy` 1) starts on the strobe that completes `cfg_hold` strobes, or earlier on a strobe whose `pp_val` differs from the value seen when latching. The new cycle resumes from the latched gain, not from `cfg_gain_init`.
- R8: If `unstable` is high at the start check, the sequencer enters back-off with the found direction set to "up". It then lowers the gain one LSB per evaluated strobe until `stable` is seen.
- R9: The gain never steps above `cfg_gain_max` or below `cfg_gain_min`. A blocked climb or back-off step latches the current gain. A blocked step during direction search restores the gain held at the start of the search and latches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_stb | input | 1 | One-cycle pulse per switching period carrying fresh monitor data |
| pp_val | input | PW | Peak-to-peak value of the compensated error for the period |
| unstable | input | 1 | Consecutive peak-to-peak difference above the upper threshold |
| stable | input | 1 | Consecutive peak-to-peak difference below the lower threshold |
| cfg_span | input | CW | Steps per leg of the direction search (S) |
| cfg_settle | input | CW | Strobes ignored after each step (Y) |
| cfg_hold | input | CW | Strobes the latched gain is held (Z) |
| cfg_steady | input | CW | Stable strobes required before a cycle (H) |
| cfg_gain_init | input | GW | Gain loaded at reset |
| cfg_gain_min | input | GW | Lowest allowed gain |
| cfg_gain_max | input | GW | Highest allowed gain |
| gain | output | GW | Compensator gain, 5 fraction bits |
| busy | output | 1 | 1 while tuning, 0 while a gain is latched |

## Verification
The hardest situations to reach are those that depend on history across many periods. One is a strobe that arrives while the settle window is still open and carries an instability flag that must not be acted on. Another is a direction search that hits the lower bound part way through and has to fall back to its starting gain. The stimulus reaches these with a reset that narrows the bounds to one LSB below the initial gain, and sets both the steady count and the settle count above one. Separate runs drive the peak-to-peak sequence so that the search resolves once upward and once downward, followed by a climb into the ceiling.

// File: rtl/gain_autotune.sv
module gain_autotune #(
  parameter int GW = 8,
  parameter int PW = 12,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          period_stb,
  input  logic [PW-1:0] pp_val,
  input  logic          unstable,
  input  logic          stable,
  input  logic [CW-1:0] cfg_span,
  input  logic [CW-1:0] cfg_settle,
  input  logic [CW-1:0] cfg_hold,
  input  logic [CW-1:0] cfg_steady,
  input  logic [GW-1:0] cfg_gain_init,
  input  logic [GW-1:0] cfg_gain_min,
  input  logic [GW-1:0] cfg_gain_max,
  output logic [GW-1:0] gain,
  output logic          busy
);

  typedef enum logic [2:0] {ST_START, ST_SEARCH, ST_CLIMB, ST_BACK, ST_HOLD} st_t;

  st_t           state;
  logic [GW-1:0] gain_q, g_origin;
  logic [PW-1:0] pp_ref, pp_hold;
  logic          dir_up;
  logic [CW:0]   dcnt;
  logic [CW-1:0] wcnt, hcnt, zcnt;

  wire [CW-1:0] span_e   = (cfg_span == '0) ? {{(CW-1){1'b0}}, 1'b1} : cfg_span;
  wire [CW-1:0] steady_e = (cfg_steady == '0) ? {{(CW-1){1'b0}}, 1'b1} : cfg_steady;
  wire [CW:0]   span1    = {1'b0, span_e};
  wire [CW:0]   span2    = {span_e, 1'b0};
  wire [CW:0]   hnext    = {1'b0, hcnt} + 1'b1;
  wire [CW:0]   znext    = {1'b0, zcnt} + 1'b1;

  wire eval    = period_stb && (wcnt == '0);
  wire can_up  = gain_q < cfg_gain_max;
  wire can_dn  = gain_q > cfg_gain_min;
  wire grew    = pp_val > pp_ref;
  wire verdict = (dcnt > span1) ? grew : !grew;
  wire fwd_ok  = dir_up ? can_up : can_dn;
  wire rev_ok  = dir_up ? can_dn : can_up;
  wire [GW-1:0] g_fwd = dir_up ? gain_q + 1'b1 : gain_q - 1'b1;
  wire [GW-1:0] g_rev = dir_up ? gain_q - 1'b1 : gain_q + 1'b1;

  assign gain = gain_q;
  assign busy = (state != ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_START;
      gain_q   <= cfg_gain_init;
      g_origin <= cfg_gain_init;
      pp_ref   <= '0;
      pp_hold  <= '0;
      dir_up   <= 1'b0;
      dcnt     <= '0;
      wcnt     <= '0;
      hcnt     <= '0;
      zcnt     <= '0;
    end else if (period_stb) begin
      if (wcnt != '0) begin
        wcnt <= wcnt - 1'b1;
      end else begin
        case (state)
          ST_START: begin
            if (unstable) begin
              dir_up <= 1'b1;
              hcnt   <= '0;
              state  <= ST_BACK;
            end else if (hnext >= {1'b0, steady_e}) begin
              hcnt     <= '0;
              g_origin <= gain_q;
              pp_ref   <= pp_val;
              if (can_dn) begin
                gain_q <= gain_q - 1'b1;
                dcnt   <= {{CW{1'b0}}, 1'b1};
                wcnt   <= cfg_settle;
                state  <= ST_SEARCH;
              end else begin
                pp_hold <= pp_val;
                zcnt    <= '0;
                state   <= ST_HOLD;
              end
            end else begin
              hcnt <= hnext[CW-1:0];
            end
          end
          ST_SEARCH: begin
            pp_ref <= pp_val;
            dcnt   <= dcnt + 1'b1;
            if (dcnt < span1) begin
              if (can_dn) begin
                gain_q <= gain_q - 1'b1;
                wcnt   <= cfg_settle;
              end else begin
                gain_q  <= g_origin;
                pp_hold <= pp_val;
                zcnt    <= '0;
                state   <= ST_HOLD;
              end
            end else if (dcnt < span2) begin
              if (can_up) begin
                gain_q <= gain_q + 1'b1;
                wcnt   <= cfg_settle;
              end else begin
                gain_q  <= g_origin;
                pp_hold <= pp_val;
                zcnt    <= '0;
                state   <= ST_HOLD;
              end
            end else begin
              dir_up <= verdict;
              if (verdict ? can_up : can_dn) begin
                gain_q <= verdict ? gain_q + 1'b1 : gain_q - 1'b1;
                wcnt   <= cfg_settle;
                state  <= ST_CLIMB;
              end else begin
                pp_hold <= pp_val;
                zcnt    <= '0;
                state   <= ST_HOLD;
              end
            end
          end
          ST_CLIMB: begin
            if (unstable) begin
              state <= ST_BACK;
              if (rev_ok) begin
                gain_q <= g_rev;
                wcnt   <= cfg_settle;
              end
            end else if (fwd_ok) begin
              gain_q <= g_fwd;
              wcnt   <= cfg_settle;
            end else begin
              pp_hold <= pp_val;
              zcnt    <= '0;
              state   <= ST_HOLD;
            end
          end
          ST_BACK: begin
            if (stable || !rev_ok) begin
              pp_hold <= pp_val;
              zcnt    <= '0;
              state   <= ST_HOLD;
            end else begin
              gain_q <= g_rev;
              wcnt   <= cfg_settle;
            end
          end
          ST_HOLD: begin
            if (pp_val != pp_hold || znext >= {1'b0, cfg_hold}) begin
              hcnt  <= '0;
              state <= ST_START;
            end else begin
              zcnt <= znext[CW-1:0];
            end
          end
          default: state <= ST_START;
        endcase
      end
    end
  end

  assert_gain_only_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !period_stb |=> $stable(gain_q));

  assert_settle_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_stb && wcnt != '0) |=> ($stable(gain_q) && $stable(state)));

  assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (period_stb && (state == ST_CLIMB || state == ST_BACK)) |=>
      (gain_q == $past(gain_q) || gain_q == $past(gain_q) + 1'b1 || gain_q == $past(gain_q) - 1'b1));

  assert_ceiling_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && state == ST_CLIMB && !unstable && dir_up && gain_q >= cfg_gain_max) |=>
      ($stable(gain_q) && !busy));

  assert_unstable_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && state == ST_START && unstable) |=> (state == ST_BACK && $stable(gain_q) && dir_up));

  assert_hold_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && state == ST_HOLD && pp_val != pp_hold) |=> busy);

  assert_latch_on_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && state == ST_BACK && stable) |=> ($stable(gain_q) && !busy));

endmodule

// File: tb/gain_autotune_bench.sv
module gain_autotune_bench;
  localparam int GW = 8;
  localparam int PW = 12;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_stb = 1'b0;
  logic [PW-1:0] pp_val = '0;
  logic unstable = 1'b0, stable = 1'b0;
  logic [CW-1:0] cfg_span = 8'd2, cfg_settle = 8'd0, cfg_hold = 8'd3, cfg_steady = 8'd1;
  logic [GW-1:0] cfg_gain_init = 8'd16, cfg_gain_min = 8'd4, cfg_gain_max = 8'd40;
  logic [GW-1:0] gain;
  logic busy;

  int checks = 0;
  int fails = 0;
  int exp_g[$];
  bit exp_b[$];
  string exp_t[$];

  always #4 clk = ~clk;

  gain_autotune #(.GW(GW), .PW(PW), .CW(CW)) u_gain_autotune (
    .clk(clk), .rst_n(rst_n), .period_stb(period_stb), .pp_val(pp_val),
    .unstable(unstable), .stable(stable), .cfg_span(cfg_span), .cfg_settle(cfg_settle),
    .cfg_hold(cfg_hold), .cfg_steady(cfg_steady), .cfg_gain_init(cfg_gain_init),
    .cfg_gain_min(cfg_gain_min), .cfg_gain_max(cfg_gain_max), .gain(gain), .busy(busy));

  task automatic compare(input int g, input bit b, input string tag);
    checks++;
    if (gain !== g[GW-1:0] || busy !== b) begin
      fails++;
      $display("FAIL %s: gain=%0d busy=%0d expected gain=%0d busy=%0d", tag, gain, busy, g, b);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (period_stb) begin
        @(negedge clk);
        if (exp_g.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard: result with no expected item");
        end else begin
          compare(exp_g.pop_front(), exp_b.pop_front(), exp_t.pop_front());
        end
      end
    end
  end

  task automatic strobe(input int pp, input bit hl, input bit ll, input int g, input bit b, input string tag);
    @(negedge clk);
    pp_val = pp[PW-1:0];
    unstable = hl;
    stable = ll;
    period_stb = 1'b1;
    exp_g.push_back(g);
    exp_b.push_back(b);
    exp_t.push_back(tag);
    @(negedge clk);
    period_stb = 1'b0;
    unstable = 1'b0;
    stable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input int init, input int mn, input int mx, input int s, input int y, input int h, input int z);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_gain_init = init[GW-1:0]; cfg_gain_min = mn[GW-1:0]; cfg_gain_max = mx[GW-1:0];
    cfg_span = s[CW-1:0]; cfg_settle = y[CW-1:0]; cfg_steady = h[CW-1:0]; cfg_hold = z[CW-1:0];
    repeat (3) @(negedge clk);
    compare(init, 1'b1, "R1 during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare(init, 1'b1, "R1 after reset");
  endtask

  initial begin
    fork
      begin
        do_reset(16, 4, 40, 2, 0, 1, 3);
        strobe(100, 0, 0, 15, 1, "R3 first step down");
        strobe( 90, 0, 0, 14, 1, "R4 down leg");
        strobe( 80, 0, 0, 15, 1, "R4 up leg");
        strobe( 90, 0, 0, 16, 1, "R4 back at origin");
        strobe(100, 0, 0, 17, 1, "R4 direction up");
        repeat (6) @(negedge clk);
        compare(17, 1, "R2 no strobe no change");
        strobe(110, 0, 0, 18, 1, "R5 climb");
        strobe(130, 1, 0, 17, 1, "R5 reverse on unstable");
        strobe(120, 0, 0, 16, 1, "R6 back-off step");
        strobe(100, 0, 1, 16, 0, "R6 latch on stable");
        strobe(100, 0, 0, 16, 0, "R7 hold 1");
        strobe(100, 0, 0, 16, 0, "R7 hold 2");
        strobe(100, 0, 0, 16, 1, "R7 hold count done");
        strobe(100, 0, 0, 15, 1, "R7 resume from latched gain");
        strobe(110, 0, 0, 14, 1, "R4 down leg grows");
        strobe(120, 0, 0, 15, 1, "R4 up leg");
        strobe(110, 0, 0, 16, 1, "R4 up leg shrinks");
        strobe(100, 0, 0, 15, 1, "R4 direction down");
        strobe( 95, 0, 0, 14, 1, "R5 climb down");
        strobe( 90, 1, 0, 15, 1, "R5 reverse up");
        strobe( 77, 0, 1, 15, 0, "R6 latch");
        strobe( 80, 0, 0, 15, 1, "R7 early exit on pp change");
        strobe( 80, 1, 0, 15, 1, "R8 unstable at start");
        strobe( 80, 0, 0, 14, 1, "R8 reduce gain");
        strobe( 80, 0, 1, 14, 0, "R8 latch when stable");

        do_reset(16, 4, 18, 2, 0, 1, 3);
        strobe(100, 0, 0, 15, 1, "R3 step down");
        strobe( 90, 0, 0, 14, 1, "R4 down leg");
        strobe( 80, 0, 0, 15, 1, "R4 up leg");
        strobe( 90, 0, 0, 16, 1, "R4 origin");
        strobe(100, 0, 0, 17, 1, "R4 direction up");
        strobe(110, 0, 0, 18, 1, "R5 climb to max");
        strobe(120, 0, 0, 18, 0, "R9 ceiling latch");

        do_reset(16, 15, 40, 2, 2, 3, 1);
        strobe(50, 0, 0, 16, 1, "R3 steady 1");
        strobe(50, 0, 0, 16, 1, "R3 steady 2");
        strobe(50, 0, 0, 15, 1, "R3 steady done step");
        strobe(50, 1, 0, 15, 1, "R2 settle ignores unstable");
        strobe(50, 0, 0, 15, 1, "R2 settle second");
        strobe(50, 0, 0, 16, 0, "R9 search abort restores origin");
        strobe(50, 0, 0, 16, 1, "R7 hold of one strobe");
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    if (exp_g.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_g.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule